// File: doc/BRIEF.md
# Workspace Context Switch Sequencer

This block is a small microsequencer for a CPU that keeps its registers in memory. The CPU holds only three real registers: a program counter (PC), a workspace pointer (WP) and a status word (ST). Register Rn is the memory word at byte address WP + 2·n. The sequencer performs the two control transfers that swap a whole register set by moving WP.

The first transfer is a call through a two-word vector, started by software or by an interrupt. The block reads the new WP and the new PC from the vector. It then writes the caller's WP, the caller's next-instruction address and the caller's ST into registers 13, 14 and 15 of the new workspace. The second transfer is a return. It reads those three registers from the current workspace and loads them back into WP, PC and ST. Interrupts use a vector at a fixed address that is set by a parameter.

Every memory access uses a single word-wide bus with a request/ready handshake. The three live registers change only at the end of a sequence, in the same cycle as a one-cycle completion pulse.

Top module: `ctx_switch_seq`

States of the sequencer:
- `S_IDLE` waits for a request. It moves to `S_VEC_WP` on an interrupt or a call, and to `S_GET_WP` on a return.
- The call path runs `S_VEC_WP` → `S_VEC_PC` → `S_PUT_WP` → `S_PUT_PC` → `S_PUT_ST` → `S_COMMIT`.
- The return path runs `S_GET_WP` → `S_GET_PC` → `S_GET_ST` → `S_COMMIT`.
- Each access state advances only in a cycle where `mem_ready` is high.
- `S_COMMIT` always returns to `S_IDLE`.

## Requirements
- R1: While reset is held and after it is released, `wp`, `pc` and `st` equal the parameters RST_WP, RST_PC and RST_ST. `busy`, `done` and `mem_req` are 0.
- R2: A call performs these five bus accesses in this order: read at V (the new WP), read at V+2 (the new PC), write old WP to newWP+26, write `next_pc` to newWP+28, write ST to newWP+30. Here V is `call_vec` for a call and IRQ_VEC for an interrupt. `mem_we` is 1 for a write.
- R3: After a call, `wp` holds the word read at V, `pc` holds the word read at V+2, and `st` is unchanged.
- R4: A return reads WP+26, WP+28 and WP+30 of the current workspace, in that order. It then loads those three words into `wp`, `pc` and `st`.
- R5: An interrupt request runs the call sequence of R2 with the vector at the parameter IRQ_VEC, and `call_vec` is not used.
- R6: When several requests are high in the same idle cycle, an interrupt is taken first, then a call, then a return. Only one sequence starts.
- R7: Requests that arrive while a sequence is running are ignored. They cause no extra bus access and do not change the result.
- R8: While `mem_req` is high and `mem_ready` is low, the next cycle keeps `mem_req` high and keeps `mem_addr`, `mem_we` and `mem_wdata` unchanged.
- R9: `done` is high for exactly one cycle at the end of every sequence. `wp`, `pc` and `st` change only on the clock edge that ends that cycle.
- R10: `mem_req` is 0 whenever `busy` is 0. `busy` is 1 from the cycle after a request is accepted through the `done` cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| call_req | input | 1 | Start a call through `call_vec` (sampled when idle) |
| call_vec | input | W | Byte address of the two-word call vector |
| ret_req | input | 1 | Start a return from the current workspace (sampled when idle) |
| irq_req | input | 1 | Start a call through the fixed interrupt vector (sampled when idle) |
| next_pc | input | W | Address of the caller's next instruction, captured when a call starts |
| mem_req | output | 1 | Bus access request |
| mem_we | output | 1 | 1 for a write, 0 for a read |
| mem_addr | output | W | Byte address of the access |
| mem_wdata | output | W | Write data |
| mem_rdata | input | W | Read data, valid when `mem_ready` is high |
| mem_ready | input | 1 | Access completes in a cycle where this input and `mem_req` are both high |
| wp | output | W | Live workspace pointer |
| pc | output | W | Live program counter |
| st | output | W | Live status word |
| busy | output | 1 | A sequence is in progress |
| done | output | 1 | One-cycle pulse when a sequence completes |

## Verification
The assertions check the following on every cycle:
- The bus request holds its address, direction and data while `mem_ready` is low.
- `done` is a single-cycle pulse.
- The live registers never change outside the commit cycle.
- There is no bus traffic while idle.
- The save states follow each other in order.

Only the bench's scenarios can show that each sequence produces the right addresses and data. These are the register offsets 26, 28 and 30 from the right workspace, the vector source, request priority, indifference to requests while busy, and the final register values. The bench covers them with bus transactions scored against a queue of expected items, under both an always-ready and a stalling memory.

// File: rtl/ctxsw_pkg.sv
package ctxsw_pkg;

    typedef enum logic [3:0] {
        S_IDLE,
        S_VEC_WP,
        S_VEC_PC,
        S_PUT_WP,
        S_PUT_PC,
        S_PUT_ST,
        S_GET_WP,
        S_GET_PC,
        S_GET_ST,
        S_COMMIT
    } seq_state_t;

    // Register numbers inside a workspace that hold the linkage words.
    localparam int unsigned LINK_WP_IDX = 13;
    localparam int unsigned LINK_PC_IDX = 14;
    localparam int unsigned LINK_ST_IDX = 15;

endpackage

// File: rtl/ctxsw_fsm.sv
module ctxsw_fsm
    import ctxsw_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       irq_req,
    input  logic       call_req,
    input  logic       ret_req,
    input  logic       mem_ready,
    output seq_state_t state,
    output logic       take_irq,
    output logic       take_call,
    output logic       take_ret,
    output logic       mem_req,
    output logic       mem_we,
    output logic       busy,
    output logic       done
);

    seq_state_t state_nx;

    // Request arbitration: interrupt, then call, then return; idle only.
    assign take_irq  = (state == S_IDLE) && irq_req;
    assign take_call = (state == S_IDLE) && call_req && !irq_req;
    assign take_ret  = (state == S_IDLE) && ret_req && !irq_req && !call_req;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE: begin
                if (take_irq || take_call) state_nx = S_VEC_WP;
                else if (take_ret)         state_nx = S_GET_WP;
            end
            S_VEC_WP: if (mem_ready) state_nx = S_VEC_PC;
            S_VEC_PC: if (mem_ready) state_nx = S_PUT_WP;
            S_PUT_WP: if (mem_ready) state_nx = S_PUT_PC;
            S_PUT_PC: if (mem_ready) state_nx = S_PUT_ST;
            S_PUT_ST: if (mem_ready) state_nx = S_COMMIT;
            S_GET_WP: if (mem_ready) state_nx = S_GET_PC;
            S_GET_PC: if (mem_ready) state_nx = S_GET_ST;
            S_GET_ST: if (mem_ready) state_nx = S_COMMIT;
            S_COMMIT: state_nx = S_IDLE;
            default:  state_nx = S_IDLE;
        endcase
    end

    always_comb begin
        mem_req = 1'b0;
        mem_we  = 1'b0;
        busy    = 1'b1;
        done    = 1'b0;
        unique case (state)
            S_IDLE:   busy = 1'b0;
            S_VEC_WP, S_VEC_PC,
            S_GET_WP, S_GET_PC, S_GET_ST: mem_req = 1'b1;
            S_PUT_WP, S_PUT_PC, S_PUT_ST: begin
                mem_req = 1'b1;
                mem_we  = 1'b1;
            end
            S_COMMIT: done = 1'b1;
            default:  busy = 1'b0;
        endcase
    end

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R10
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mem_req);

    // R2
    save_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_PUT_WP) && mem_ready |=> (state == S_PUT_PC));

endmodule

// File: rtl/ctxsw_ctx_regs.sv
module ctxsw_ctx_regs
    import ctxsw_pkg::*;
#(
    parameter int unsigned W       = 16,
    parameter logic [W-1:0] RST_WP  = '0,
    parameter logic [W-1:0] RST_PC  = '0,
    parameter logic [W-1:0] RST_ST  = '0,
    parameter logic [W-1:0] IRQ_VEC = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  seq_state_t   state,
    input  logic         take_irq,
    input  logic         take_call,
    input  logic [W-1:0] call_vec,
    input  logic [W-1:0] next_pc,
    input  logic [W-1:0] mem_rdata,
    input  logic         mem_ready,
    output logic [W-1:0] wp_q,
    output logic [W-1:0] pc_q,
    output logic [W-1:0] st_q,
    output logic [W-1:0] vec_base,
    output logic [W-1:0] stage_wp,
    output logic [W-1:0] saved_pc
);

    logic [W-1:0] stage_pc;
    logic [W-1:0] stage_st;
    logic         commit;

    assign commit = (state == S_COMMIT);

    // Staging registers: filled during the sequence, applied at commit.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vec_base <= '0;
            saved_pc <= '0;
            stage_wp <= '0;
            stage_pc <= '0;
            stage_st <= '0;
        end else begin
            if (take_irq || take_call) begin
                vec_base <= take_irq ? IRQ_VEC : call_vec;
                saved_pc <= next_pc;
                stage_st <= st_q;
            end
            if (mem_ready) begin
                unique case (state)
                    S_VEC_WP, S_GET_WP: stage_wp <= mem_rdata;
                    S_VEC_PC, S_GET_PC: stage_pc <= mem_rdata;
                    S_GET_ST:           stage_st <= mem_rdata;
                    default: ;
                endcase
            end
        end
    end

    // Live CPU state.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wp_q <= RST_WP;
            pc_q <= RST_PC;
            st_q <= RST_ST;
        end else if (commit) begin
            wp_q <= stage_wp;
            pc_q <= stage_pc;
            st_q <= stage_st;
        end
    end

    // R9
    ctx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !commit |=> ($stable(wp_q) && $stable(pc_q) && $stable(st_q)));

endmodule

// File: rtl/ctxsw_bus_mux.sv
module ctxsw_bus_mux
    import ctxsw_pkg::*;
#(
    parameter int unsigned W = 16
) (
    input  seq_state_t   state,
    input  logic [W-1:0] vec_base,
    input  logic [W-1:0] stage_wp,
    input  logic [W-1:0] cur_wp,
    input  logic [W-1:0] saved_pc,
    input  logic [W-1:0] cur_st,
    output logic [W-1:0] mem_addr,
    output logic [W-1:0] mem_wdata
);

    localparam logic [W-1:0] OFS_WP  = W'(2 * LINK_WP_IDX);
    localparam logic [W-1:0] OFS_PC  = W'(2 * LINK_PC_IDX);
    localparam logic [W-1:0] OFS_ST  = W'(2 * LINK_ST_IDX);
    localparam logic [W-1:0] WORD_SZ = W'(2);

    always_comb begin
        mem_addr  = '0;
        mem_wdata = '0;
        unique case (state)
            S_VEC_WP: mem_addr = vec_base;
            S_VEC_PC: mem_addr = vec_base + WORD_SZ;
            S_PUT_WP: begin
                mem_addr  = stage_wp + OFS_WP;
                mem_wdata = cur_wp;
            end
            S_PUT_PC: begin
                mem_addr  = stage_wp + OFS_PC;
                mem_wdata = saved_pc;
            end
            S_PUT_ST: begin
                mem_addr  = stage_wp + OFS_ST;
                mem_wdata = cur_st;
            end
            S_GET_WP: mem_addr = cur_wp + OFS_WP;
            S_GET_PC: mem_addr = cur_wp + OFS_PC;
            S_GET_ST: mem_addr = cur_wp + OFS_ST;
            default: ;
        endcase
    end

endmodule

// File: rtl/ctx_switch_seq.sv
module ctx_switch_seq
    import ctxsw_pkg::*;
#(
    parameter int unsigned W       = 16,
    parameter logic [W-1:0] RST_WP  = 16'h0100,
    parameter logic [W-1:0] RST_PC  = 16'h0000,
    parameter logic [W-1:0] RST_ST  = 16'h0000,
    parameter logic [W-1:0] IRQ_VEC = 16'h0004
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         call_req,
    input  logic [W-1:0] call_vec,
    input  logic         ret_req,
    input  logic         irq_req,
    input  logic [W-1:0] next_pc,
    output logic         mem_req,
    output logic         mem_we,
    output logic [W-1:0] mem_addr,
    output logic [W-1:0] mem_wdata,
    input  logic [W-1:0] mem_rdata,
    input  logic         mem_ready,
    output logic [W-1:0] wp,
    output logic [W-1:0] pc,
    output logic [W-1:0] st,
    output logic         busy,
    output logic         done
);

    seq_state_t   state;
    logic         take_irq, take_call, take_ret;
    logic [W-1:0] vec_base, stage_wp, saved_pc;

    ctxsw_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .irq_req   (irq_req),
        .call_req  (call_req),
        .ret_req   (ret_req),
        .mem_ready (mem_ready),
        .state     (state),
        .take_irq  (take_irq),
        .take_call (take_call),
        .take_ret  (take_ret),
        .mem_req   (mem_req),
        .mem_we    (mem_we),
        .busy      (busy),
        .done      (done)
    );

    ctxsw_ctx_regs #(
        .W       (W),
        .RST_WP  (RST_WP),
        .RST_PC  (RST_PC),
        .RST_ST  (RST_ST),
        .IRQ_VEC (IRQ_VEC)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .state     (state),
        .take_irq  (take_irq),
        .take_call (take_call),
        .call_vec  (call_vec),
        .next_pc   (next_pc),
        .mem_rdata (mem_rdata),
        .mem_ready (mem_ready),
        .wp_q      (wp),
        .pc_q      (pc),
        .st_q      (st),
        .vec_base  (vec_base),
        .stage_wp  (stage_wp),
        .saved_pc  (saved_pc)
    );

    ctxsw_bus_mux #(.W(W)) u_mux (
        .state     (state),
        .vec_base  (vec_base),
        .stage_wp  (stage_wp),
        .cur_wp    (wp),
        .saved_pc  (saved_pc),
        .cur_st    (st),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata)
    );

    // R8
    bus_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ready |=> mem_req && $stable(mem_addr)
                                  && $stable(mem_we) && $stable(mem_wdata));

    // R10
    start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (take_irq || take_call || take_ret) |=> busy);

endmodule

// File: tb/ctx_switch_seq_bench.sv
module ctx_switch_seq_bench;

    localparam int CLK_PERIOD = 10;
    localparam int WD_CYCLES  = 20000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        call_req = 1'b0, ret_req = 1'b0, irq_req = 1'b0;
    logic [15:0] call_vec = '0, next_pc = '0;
    logic        mem_req, mem_we, mem_ready;
    logic [15:0] mem_addr, mem_wdata, mem_rdata;
    logic [15:0] wp, pc, st;
    logic        busy, done;

    always #(CLK_PERIOD/2) clk = ~clk;

    ctx_switch_seq u_ctx_switch_seq (
        .clk(clk), .rst_n(rst_n), .call_req(call_req), .call_vec(call_vec),
        .ret_req(ret_req), .irq_req(irq_req), .next_pc(next_pc),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ready(mem_ready),
        .wp(wp), .pc(pc), .st(st), .busy(busy), .done(done)
    );

    // Memory model: 1024 words, byte address bits [10:1].
    logic [15:0] mem [0:1023];
    logic        poke_en = 1'b0;
    logic [15:0] poke_a = '0, poke_d = '0;
    assign mem_rdata = mem[mem_addr[10:1]];

    always @(posedge clk) begin
        if (poke_en) mem[poke_a[10:1]] <= poke_d;
        else if (mem_req && mem_ready && mem_we) mem[mem_addr[10:1]] <= mem_wdata;
    end

    logic slow = 1'b0;
    int   rdy_cnt = 0;
    always @(negedge clk) begin
        rdy_cnt   <= rdy_cnt + 1;
        mem_ready <= slow ? (rdy_cnt % 3 == 2) : 1'b1;
    end

    // Scoreboard of expected bus transactions.
    typedef struct packed { logic we; logic [15:0] a; logic [15:0] d; } txn_t;
    txn_t exp_q[$];
    string exp_tag[$];
    int mon_checks = 0, mon_fails = 0;

    always @(posedge clk) begin
        if (rst_n && mem_req && mem_ready) begin
            txn_t  e;
            txn_t  got;
            string tg;
            got = '{we: mem_we, a: mem_addr, d: (mem_we ? mem_wdata : mem_rdata)};
            mon_checks++;
            if (exp_q.size() == 0) begin
                mon_fails++;
                $display("FAIL R7 unexpected bus access actual=%h expected=none", got);
            end else begin
                e  = exp_q.pop_front();
                tg = exp_tag.pop_front();
                if (got !== e) begin
                    mon_fails++;
                    $display("FAIL %s bus txn actual we=%b a=%h d=%h expected we=%b a=%h d=%h",
                             tg, got.we, got.a, got.d, e.we, e.a, e.d);
                end
            end
        end
    end

    int n_checks = 0, n_fails = 0;

    task automatic chk(input logic ok, input string req, input logic [15:0] act,
                       input logic [15:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic expect_txn(input logic we, input logic [15:0] a, input logic [15:0] d,
                              input string tg);
        exp_q.push_back('{we: we, a: a, d: d});
        exp_tag.push_back(tg);
    endtask

    task automatic poke(input logic [15:0] a, input logic [15:0] d);
        @(negedge clk); poke_a = a; poke_d = d; poke_en = 1'b1;
        @(negedge clk); poke_en = 1'b0;
    endtask

    // Expect a call through vector v with words nw/npc; old state ow/os.
    task automatic expect_call(input logic [15:0] v, input logic [15:0] nw,
                               input logic [15:0] npc, input logic [15:0] ow,
                               input logic [15:0] npc_in, input logic [15:0] os,
                               input string tg);
        expect_txn(1'b0, v,             nw,     tg);
        expect_txn(1'b0, v + 16'd2,     npc,    tg);
        expect_txn(1'b1, nw + 16'd26,   ow,     tg);
        expect_txn(1'b1, nw + 16'd28,   npc_in, tg);
        expect_txn(1'b1, nw + 16'd30,   os,     tg);
    endtask

    task automatic expect_ret(input logic [15:0] cw, input logic [15:0] rw,
                              input logic [15:0] rp, input logic [15:0] rs,
                              input string tg);
        expect_txn(1'b0, cw + 16'd26, rw, tg);
        expect_txn(1'b0, cw + 16'd28, rp, tg);
        expect_txn(1'b0, cw + 16'd30, rs, tg);
    endtask

    task automatic pulse(input logic i, input logic c, input logic r);
        @(negedge clk); irq_req = i; call_req = c; ret_req = r;
        @(negedge clk); irq_req = 0; call_req = 0; ret_req = 0;
    endtask

    // Waits for done, checks width and final registers.
    task automatic finish_seq(input logic [15:0] ew, input logic [15:0] ep,
                              input logic [15:0] es, input string tg);
        while (!done) @(negedge clk);
        chk(busy === 1'b1, "R10 busy during done", {15'd0, busy}, 16'd1);
        @(negedge clk);
        chk(done === 1'b0, "R9 done one cycle", {15'd0, done}, 16'd0);
        chk(wp === ew, {tg, " wp"}, wp, ew);
        chk(pc === ep, {tg, " pc"}, pc, ep);
        chk(st === es, {tg, " st"}, st, es);
        chk(busy === 1'b0 && mem_req === 1'b0, "R10 idle quiet",
            {14'd0, busy, mem_req}, 16'd0);
        chk(exp_q.size() == 0, {tg, " all txns seen"}, 16'(exp_q.size()), 16'd0);
    endtask

    initial begin : watchdog
        repeat (WD_CYCLES) @(posedge clk);
        $display("FAIL watchdog expired actual=hung expected=finished");
        $display("[TB] %0d tests run, %0d failed",
                 n_checks + mon_checks + 1, n_fails + mon_fails + 1);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset values
        chk(wp === 16'h0100, "R1 reset wp", wp, 16'h0100);
        chk(pc === 16'h0000 && st === 16'h0000, "R1 reset pc/st", pc | st, 16'h0000);
        chk(!busy && !done && !mem_req, "R1 reset idle", {13'd0, busy, done, mem_req}, 16'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(wp === 16'h0100 && !busy, "R1 after release", wp, 16'h0100);

        // R2/R3: plain call, fast memory
        poke(16'h0040, 16'h0200);
        poke(16'h0042, 16'h0300);
        call_vec = 16'h0040; next_pc = 16'h1234;
        expect_call(16'h0040, 16'h0200, 16'h0300, 16'h0100, 16'h1234, 16'h0000, "R2");
        pulse(0, 1, 0);
        finish_seq(16'h0200, 16'h0300, 16'h0000, "R3");

        // R4: return restores caller
        expect_ret(16'h0200, 16'h0100, 16'h1234, 16'h0000, "R4");
        pulse(0, 0, 1);
        finish_seq(16'h0100, 16'h1234, 16'h0000, "R4");

        // R4: return loading a non-zero status, stalling memory (R8)
        poke(16'h011A, 16'h0300);
        poke(16'h011C, 16'h0456);
        poke(16'h011E, 16'hC00F);
        slow = 1'b1;
        expect_ret(16'h0100, 16'h0300, 16'h0456, 16'hC00F, "R4");
        pulse(0, 0, 1);
        finish_seq(16'h0300, 16'h0456, 16'hC00F, "R4 slow");

        // R5: interrupt through the fixed vector, call_vec ignored
        poke(16'h0004, 16'h0380);
        poke(16'h0006, 16'h0500);
        call_vec = 16'h0040; next_pc = 16'h0777;
        expect_call(16'h0004, 16'h0380, 16'h0500, 16'h0300, 16'h0777, 16'hC00F, "R5");
        pulse(1, 0, 0);
        finish_seq(16'h0380, 16'h0500, 16'hC00F, "R5 R3");

        // R6: all three at once, interrupt wins
        slow = 1'b0;
        poke(16'h0004, 16'h0280);
        poke(16'h0006, 16'h0600);
        next_pc = 16'h0888;
        expect_call(16'h0004, 16'h0280, 16'h0600, 16'h0380, 16'h0888, 16'hC00F, "R6");
        pulse(1, 1, 1);
        finish_seq(16'h0280, 16'h0600, 16'hC00F, "R6 irq");

        // R6: call and return together, call wins
        poke(16'h0060, 16'h0140);
        poke(16'h0062, 16'h0700);
        call_vec = 16'h0060; next_pc = 16'h0999;
        expect_call(16'h0060, 16'h0140, 16'h0700, 16'h0280, 16'h0999, 16'hC00F, "R6");
        pulse(0, 1, 1);
        finish_seq(16'h0140, 16'h0700, 16'hC00F, "R6 call");

        // R7: requests during a slow return are ignored
        slow = 1'b1;
        expect_ret(16'h0140, 16'h0280, 16'h0999, 16'hC00F, "R7");
        pulse(0, 0, 1);
        pulse(0, 1, 0);
        pulse(1, 0, 0);
        finish_seq(16'h0280, 16'h0999, 16'hC00F, "R7");
        repeat (6) @(negedge clk);
        chk(wp === 16'h0280 && !busy, "R7 no late start", wp, 16'h0280);

        repeat (2) @(negedge clk);
        $display("[TB] %0d tests run, %0d failed",
                 n_checks + mon_checks, n_fails + mon_fails);
        $finish;
    end

endmodule